// File: doc/BRIEF.md
# Parallel Display Write Strobe Generator

This block sits between an on-chip pixel or command producer and the write-only parallel bus of an external display controller. It accepts one wide write request at a time. Each request has a data word, per-byte enables and a select bit that tells command from data. The block breaks the word into 16-bit bus beats and drives chip select, the write strobe, the command/data line and the data bus for each beat. Software sets the timing. Address setup, data setup and bus turnaround are each a count of controller clock cycles, so a faster producer can never break the display's minimum write cycle.

Each beat lasts address-setup plus data-setup plus one cycles. Chip select is low for the whole beat. The write strobe is low only during the data-setup part, and the last cycle holds the data with the strobe high so the display samples on a clean rising edge. The access-mode input decides whether the turnaround gap also separates beats cut from the same word. The gap always follows the last beat of a word. The ready output stays low while a word is on the bus, and this holds the producer back.

Top module: `pbus_write_ctrl`

## Requirements
- R1: After reset, chip select and write strobe are high (inactive) and ready is high.
- R2: A beat keeps chip select low for A+D+1 cycles, where A is the address-setup count and D the data-setup count. Within the beat the write strobe is high for the first A cycles, low for the next D cycles, and high for the final cycle.
- R3: A data-setup count of zero is treated as one cycle.
- R4: Beat i carries word bits [16i+15:16i]. Beats go out in ascending i, each at most once.
- R5: Beat i is sent only if at least one of its byte enables (bits 2i and 2i+1 of the enable field) is set. A word with no enable set is consumed without bus activity, and ready stays high in the next cycle.
- R6: With access mode 0, beats of one word run back-to-back with chip select held low between them.
- R7: With access mode 1, chip select goes high for the turnaround count T between beats of one word.
- R8: After the last beat of a word, chip select stays high for T cycles before the next word can start.
- R9: Ready falls in the cycle after a word with any enabled beat is accepted. It rises again once the trailing turnaround ends, and it is never high while chip select is low.
- R10: The command/data line takes the request's select bit at acceptance and keeps it for all beats of that word.
- R11: The data bus stays constant across the rising edge of the write strobe and for the whole of each beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block can take a request |
| req_data | input | IN_W | Word to write |
| req_be | input | IN_W/8 | Byte enables of the word |
| req_dc | input | 1 | Command (0) or data (1) select, from a request address bit |
| cfg_addset | input | 4 | Address-setup cycles (0 allowed) |
| cfg_datast | input | 4 | Data-setup cycles (0 treated as 1) |
| cfg_busturn | input | 4 | Turnaround cycles |
| cfg_mode | input | 1 | 0: split beats back-to-back, 1: turnaround between split beats |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_dc | output | 1 | Command/data line |
| bus_data | output | 16 | Parallel data bus |

## Verification
The bench sweeps every combination of address setup, data setup and turnaround from 0 to 3 in both access modes. Each combination uses five enable patterns: both halves, low half only, high half only, a single byte of the upper half, and none. The bench predicts the level of every pin in every cycle arithmetically. The two-beat pattern separates mode 0 from mode 1 by whether a gap appears between the halves. The single-half patterns show that a missing beat is skipped and that the remaining beat carries the right half. The empty pattern shows that a word can be consumed without bus activity. A data-setup count of zero shows the strobe stretched to one cycle, and a turnaround of zero shows that words can follow each other with no idle cycle.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    // Width of every programmable phase count
    localparam int PH_W      = 4;
    // Upper bound on beats per word (IN_W / BUS_W must not exceed it)
    localparam int MAX_BEATS = 8;
    localparam int BIDX_W    = $clog2(MAX_BEATS);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_DATA,
        PH_HOLD,
        PH_TURN
    } phase_e;

    typedef struct packed {
        logic            mode;
        logic [PH_W-1:0] turn;
        logic [PH_W-1:0] dset;
        logic [PH_W-1:0] aset;
    } timing_t;

    // Index of the lowest set bit; zero when none is set
    function automatic logic [BIDX_W-1:0] lowest_set(input logic [MAX_BEATS-1:0] m);
        logic [BIDX_W-1:0] r;
        r = '0;
        for (int i = MAX_BEATS - 1; i >= 0; i--) begin
            if (m[i]) r = BIDX_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/pbus_beat_sel.sv
module pbus_beat_sel
    import pbus_pkg::*;
#(
    parameter int IN_W  = 32,
    parameter int BUS_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               advance,
    input  logic [IN_W-1:0]    word_in,
    input  logic [IN_W/8-1:0]  be_in,
    output logic               in_any,
    output logic               more,
    output logic [BUS_W-1:0]   beat_data
);
    localparam int NB    = IN_W / BUS_W;
    localparam int BPB   = BUS_W / 8;
    localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;

    logic [NB-1:0]        mask_in;
    logic [NB-1:0]        src_mask;
    logic [NB-1:0]        clr;
    logic [NB-1:0]        rem_q;
    logic [IN_W-1:0]      word_q;
    logic [IN_W-1:0]      src_word;
    logic [MAX_BEATS-1:0] pad;
    logic [IDX_W-1:0]     pick;
    logic [BUS_W-1:0]     beat_nx;
    logic [BUS_W-1:0]     beat_q;

    for (genvar g = 0; g < NB; g++) begin : g_mask
        assign mask_in[g] = |be_in[g*BPB +: BPB];
    end

    assign src_mask = load ? mask_in : rem_q;
    assign src_word = load ? word_in : word_q;

    always_comb begin
        pad          = '0;
        pad[NB-1:0]  = src_mask;
        pick         = IDX_W'(lowest_set(pad));
        beat_nx      = '0;
        clr          = '0;
        for (int i = 0; i < NB; i++) begin
            if (pick == IDX_W'(i)) begin
                beat_nx = src_word[i*BUS_W +: BUS_W];
                clr[i]  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            rem_q  <= '0;
            beat_q <= '0;
        end else if (load || advance) begin
            if (load) word_q <= word_in;
            rem_q  <= src_mask & ~clr;
            beat_q <= beat_nx;
        end
    end

    assign in_any    = |mask_in;
    assign more      = |rem_q;
    assign beat_data = beat_q;

    // Pending beats only shrink between loads, so no beat is sent twice
    assert_rem_shrinks_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(load) |-> ((rem_q & ~$past(rem_q)) == '0));

endmodule

// File: rtl/pbus_phase_fsm.sv
module pbus_phase_fsm
    import pbus_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    more,
    input  timing_t tcfg,
    output phase_e  phase_d,
    output logic    step,
    output logic    idle
);
    phase_e          phase_q;
    logic [PH_W-1:0] cnt_q;
    logic [PH_W-1:0] cnt_d;
    logic [PH_W-1:0] dlen_m1;
    logic [PH_W-1:0] turn_m1;
    phase_e          beat_ph;
    logic [PH_W-1:0] beat_cnt;
    logic            split_gap;

    assign dlen_m1   = (tcfg.dset == '0) ? '0 : tcfg.dset - PH_W'(1);
    assign turn_m1   = tcfg.turn - PH_W'(1);
    assign beat_ph   = (tcfg.aset != '0) ? PH_ADDR : PH_DATA;
    assign beat_cnt  = (tcfg.aset != '0) ? tcfg.aset - PH_W'(1) : dlen_m1;
    assign split_gap = tcfg.mode && (tcfg.turn != '0);

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        step    = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    phase_d = beat_ph;
                    cnt_d   = beat_cnt;
                end
            end
            PH_ADDR: begin
                if (cnt_q == '0) begin
                    phase_d = PH_DATA;
                    cnt_d   = dlen_m1;
                end else begin
                    cnt_d = cnt_q - PH_W'(1);
                end
            end
            PH_DATA: begin
                if (cnt_q == '0) phase_d = PH_HOLD;
                else             cnt_d   = cnt_q - PH_W'(1);
            end
            PH_HOLD: begin
                if (more && !split_gap) begin
                    step    = 1'b1;
                    phase_d = beat_ph;
                    cnt_d   = beat_cnt;
                end else if (more || tcfg.turn != '0) begin
                    phase_d = PH_TURN;
                    cnt_d   = turn_m1;
                end else begin
                    phase_d = PH_IDLE;
                end
            end
            PH_TURN: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - PH_W'(1);
                end else if (more) begin
                    step    = 1'b1;
                    phase_d = beat_ph;
                    cnt_d   = beat_cnt;
                end else begin
                    phase_d = PH_IDLE;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    assign idle = (phase_q == PH_IDLE);

    // The hold cycle that closes each beat is exactly one cycle long
    assert_hold_single_R2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HOLD) |=> (phase_q != PH_HOLD));

    // The address-phase counter never starts above the programmed setup
    assert_addr_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ADDR) |-> (cnt_q < tcfg.aset));

endmodule

// File: rtl/pbus_pin_drv.sv
module pbus_pin_drv
    import pbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e phase_d,
    input  logic   accept,
    input  logic   dc_in,
    output logic   cs_n,
    output logic   wr_n,
    output logic   dc
);
    // Pins come straight from flops so the display sees no decode glitches
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n <= 1'b1;
            wr_n <= 1'b1;
            dc   <= 1'b0;
        end else begin
            cs_n <= !(phase_d inside {PH_ADDR, PH_DATA, PH_HOLD});
            wr_n <= (phase_d != PH_DATA);
            if (accept) dc <= dc_in;
        end
    end

endmodule

// File: rtl/pbus_write_ctrl.sv
module pbus_write_ctrl
    import pbus_pkg::*;
#(
    parameter int IN_W  = 32,
    parameter int BUS_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [IN_W-1:0]     req_data,
    input  logic [IN_W/8-1:0]   req_be,
    input  logic                req_dc,
    input  logic [PH_W-1:0]     cfg_addset,
    input  logic [PH_W-1:0]     cfg_datast,
    input  logic [PH_W-1:0]     cfg_busturn,
    input  logic                cfg_mode,
    output logic                bus_cs_n,
    output logic                bus_wr_n,
    output logic                bus_dc,
    output logic [BUS_W-1:0]    bus_data
);
    timing_t tcfg;
    phase_e  phase_d;
    logic    accept;
    logic    in_any;
    logic    more;
    logic    step;
    logic    idle;

    assign tcfg   = '{mode: cfg_mode, turn: cfg_busturn, dset: cfg_datast, aset: cfg_addset};
    assign accept = req_valid && idle;

    pbus_beat_sel #(.IN_W(IN_W), .BUS_W(BUS_W)) u_sel (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .advance   (step),
        .word_in   (req_data),
        .be_in     (req_be),
        .in_any    (in_any),
        .more      (more),
        .beat_data (bus_data)
    );

    pbus_phase_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (accept && in_any),
        .more    (more),
        .tcfg    (tcfg),
        .phase_d (phase_d),
        .step    (step),
        .idle    (idle)
    );

    pbus_pin_drv u_pins (
        .clk     (clk),
        .rst     (rst),
        .phase_d (phase_d),
        .accept  (accept),
        .dc_in   (req_dc),
        .cs_n    (bus_cs_n),
        .wr_n    (bus_wr_n),
        .dc      (bus_dc)
    );

    assign req_ready = idle;

    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (rst)
        !bus_cs_n |-> !req_ready);

    assert_data_at_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_wr_n) |-> $stable(bus_data));

    assert_dc_steady_R10: assert property (@(posedge clk) disable iff (rst)
        (!bus_cs_n && !$past(bus_cs_n)) |-> $stable(bus_dc));

    assert_setup_before_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        ($fell(bus_wr_n) && cfg_addset != '0) |-> !$past(bus_cs_n));

    assert_empty_word_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_be == '0) |=> req_ready);

endmodule

// File: tb/pbus_write_ctrl_bench.sv
`timescale 1ns/1ps
module pbus_write_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_data = '0;
    logic [3:0]  req_be = '0;
    logic        req_dc = 1'b0;
    logic [3:0]  cfg_addset = '0;
    logic [3:0]  cfg_datast = '0;
    logic [3:0]  cfg_busturn = '0;
    logic        cfg_mode = 1'b0;
    logic        bus_cs_n;
    logic        bus_wr_n;
    logic        bus_dc;
    logic [15:0] bus_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pbus_write_ctrl u_pbus_write_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_data(req_data), .req_be(req_be), .req_dc(req_dc),
        .cfg_addset(cfg_addset), .cfg_datast(cfg_datast),
        .cfg_busturn(cfg_busturn), .cfg_mode(cfg_mode),
        .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .bus_dc(bus_dc), .bus_data(bus_data)
    );

    // Sends one word and compares every pin in every cycle against a
    // timeline computed from the timing counts (R2, R3, R4, R5, R6, R7, R8, R9, R10, R11)
    task automatic run_word(input logic m, input int a, input int d, input int t,
                            input logic [3:0] be, input logic [31:0] w, input logic dcv);
        int dm = (d == 0) ? 1 : d;
        int L  = a + dm + 1;
        int g  = m ? t : 0;
        int nb = 0;
        int idx[2];
        int total;
        bit bad = 0;
        for (int i = 0; i < 2; i++) begin
            if (be[2*i] || be[2*i+1]) begin
                idx[nb] = i;
                nb++;
            end
        end
        total = (nb == 0) ? 0 : nb * L + (nb - 1) * g + t;
        cfg_mode = m; cfg_addset = 4'(a); cfg_datast = 4'(d); cfg_busturn = 4'(t);
        req_valid = 1'b1; req_data = w; req_be = be; req_dc = dcv;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 1; c <= total + 1; c++) begin
            int p = c - 1;
            bit e_cs = 1, e_wr = 1, e_rdy = 1, done = 0;
            logic [15:0] e_dat = '0;
            string tag = "R9";
            int reg_kind = 3;
            for (int k = 0; k < nb; k++) begin
                if (!done) begin
                    if (p < L) begin
                        e_cs = 0; e_rdy = 0; done = 1; reg_kind = 0;
                        e_wr = !(p >= a && p < a + dm);
                        e_dat = w[idx[k]*16 +: 16];
                        tag = (p == L - 1) ? "R11" : ((d == 0) ? "R3" : "R2");
                    end else begin
                        int gap;
                        p = p - L;
                        gap = (k < nb - 1) ? g : t;
                        if (p < gap) begin
                            e_rdy = 0; done = 1;
                            reg_kind = (k < nb - 1) ? 1 : 2;
                        end else begin
                            p = p - gap;
                        end
                    end
                end
            end
            if (!bad) begin
                bit mis_cs  = (bus_cs_n !== e_cs);
                bit mis_wr  = (bus_wr_n !== e_wr);
                bit mis_rdy = (req_ready !== e_rdy);
                bit mis_dat = !e_cs && (bus_data !== e_dat);
                bit mis_dc  = !e_cs && (bus_dc !== dcv);
                if (mis_cs || mis_wr || mis_rdy || mis_dat || mis_dc) begin
                    bad = 1;
                    if (nb == 0) tag = "R5";
                    else if (mis_dc) tag = "R10";
                    else if (mis_dat && reg_kind == 0 && tag != "R11") tag = "R4";
                    else if (reg_kind == 1) tag = m ? "R7" : "R6";
                    else if (reg_kind == 2) tag = "R8";
                    else if (reg_kind == 3 && mis_cs) tag = "R8";
                    else if (mis_rdy && !mis_cs && !mis_wr && !mis_dat) tag = "R9";
                    $display("FAIL %s m=%0d a=%0d d=%0d t=%0d be=%h cyc=%0d: cs/wr/rdy/dc/data act=%b%b%b%b/%h exp=%b%b%b%b/%h",
                             tag, m, a, d, t, be, c, bus_cs_n, bus_wr_n, req_ready, bus_dc, bus_data,
                             e_cs, e_wr, e_rdy, dcv, e_dat);
                end
            end
            if (c <= total) @(negedge clk);
        end
        checks++;
        if (bad) errors++;
    endtask

    initial begin
        logic [3:0] pats[5];
        int n = 0;
        pats = '{4'b1111, 4'b0011, 4'b1100, 4'b0100, 4'b0000};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle levels after reset
        checks++;
        if (bus_cs_n !== 1'b1 || bus_wr_n !== 1'b1 || req_ready !== 1'b1) begin
            errors++;
            $display("FAIL R1 reset: cs/wr/rdy act=%b%b%b exp=111", bus_cs_n, bus_wr_n, req_ready);
        end
        for (int m = 0; m < 2; m++)
            for (int a = 0; a < 4; a++)
                for (int d = 0; d < 4; d++)
                    for (int t = 0; t < 4; t++)
                        for (int q = 0; q < 5; q++) begin
                            run_word(1'(m), a, d, t, pats[q], 32'hC0DE_5A00 ^ (32'(n) * 32'h0001_0F37), 1'(n));
                            n++;
                        end
        // R6 vs R7: the reference setting 1/3 with turnaround 2 in both modes
        run_word(1'b0, 1, 3, 2, 4'b1111, 32'h1234_ABCD, 1'b1);
        run_word(1'b1, 1, 3, 2, 4'b1111, 32'hFEDC_0123, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, act=running exp=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule